// File: doc/BRIEF.md
# Serial Command Word Loader

This block accepts 16-bit command words on a three-wire serial link: an active-low frame line that doubles as chip enable, a serial clock, and a data line. Bits are taken on falling clock edges, most significant first, while the frame line is low. Each completed word is handed to the system clock domain. There it is decoded into a one-cycle write strobe for the target register, with the 12-bit payload presented alongside.

The top four bits of a word select the target and the low twelve bits carry the payload. Target 0 is the control register. Targets 1 to NUM_PARAM are parameter slots. A wide parameter is written as two 12-bit halves at two separate targets. Every control write also pulses a sequencer reset for the rest of the chip. A single frame may carry any number of back-to-back words.

Top module: `serial_cmd_loader`

## Requirements
- R1: Bits are collected only while `sync_ni` is low. A high `sync_ni` clears the bit count, so a frame that ends before its 16th falling edge produces no write, and clock edges seen while the frame line is high produce no write.
- R2: A word is the 16 `sdata_i` values sampled on consecutive falling edges of `sclk_i`, first bit in bit 15. Bits 15..12 are the target and bits 11..0 the payload.
- R3: If `sync_ni` stays low, each further group of 16 falling edges forms a new word, and every word in the frame is written in order.
- R4: A word with target 0 pulses `ctrl_we_o` and presents bits 11..0 on `wr_data_o` in the same cycle.
- R5: A word with target k, for 1 <= k <= NUM_PARAM (7 by default), pulses `param_we_o[k-1]` and presents its payload on `wr_data_o`.
- R6: `seq_rst_o` pulses in exactly the cycles in which `ctrl_we_o` pulses.
- R7: Words with a target above NUM_PARAM raise no strobe and leave `wr_data_o` unchanged.
- R8: Every strobe is high for one `clk_i` cycle, and no two strobes are high together.
- R9: Capture works whether `sclk_i` idles high between frames, idles low, or runs continuously.
- R10: After reset, all strobes are low and `wr_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sync_ni | input | 1 | Active-low frame and enable line |
| sdata_i | input | 1 | Serial data, most significant bit first |
| ctrl_we_o | output | 1 | Control register write strobe |
| param_we_o | output | NUM_PARAM | One-hot parameter slot write strobes, bit k-1 for target k |
| seq_rst_o | output | 1 | Sequencer reset pulse issued with each control write |
| wr_data_o | output | 12 | Payload of the last accepted write |

## Verification
A stale bit counter shows up as a shifted target or payload on the next full word. This appears within the first frame after the fault, either as a strobe on the wrong line or as a wrong `wr_data_o` value. A fault in the handshake between clock domains shows within four system cycles of the 16th falling edge: the strobe is missing, repeated, or wider than one cycle. A fault in the decoder shows in the same cycle as the strobe, as a reserved target that fires a strobe or moves `wr_data_o`, or as a control write that arrives without its reset pulse.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = WORD_W - ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/serial_shift_in.sv
`timescale 1ns/1ps
module serial_shift_in
  import scl_pkg::*;
(
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  logic      sync_ni,
  input  logic      sdata_i,
  output cmd_word_t word_o,
  output logic      tog_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] shift_q;
  cmd_word_t         word_q;
  logic              tog_q;
  logic              last_bit;

  assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));

  // frame line high holds the counter cleared, dropping partial words
  always_ff @(negedge sclk_i or negedge rst_ni or posedge sync_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (sync_ni)  cnt_q <= '0;
    else if (last_bit) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(negedge sclk_i) begin
    shift_q <= {shift_q[WORD_W-3:0], sdata_i};
  end

  // completed word is held for 16 serial edges while the system side samples it
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else if (last_bit) begin
      word_q <= {shift_q, sdata_i};
      tog_q  <= ~tog_q;
    end
  end

  assign word_o = word_q;
  assign tog_o  = tog_q;
endmodule

// File: rtl/toggle_sync.sv
`timescale 1ns/1ps
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic pulse_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], tog_i};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/cmd_decode.sv
`timescale 1ns/1ps
module cmd_decode
  import scl_pkg::*;
#(
  parameter int unsigned NUM_PARAM = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_i,
  input  cmd_word_t            word_i,
  output logic                 ctrl_we_o,
  output logic [NUM_PARAM-1:0] param_we_o,
  output logic                 seq_rst_o,
  output logic [DATA_W-1:0]    data_o
);
  logic                 hit_ctrl;
  logic [NUM_PARAM-1:0] hit_par;
  logic                 any_hit;

  logic                 ctrl_q;
  logic [NUM_PARAM-1:0] par_q;
  logic                 rst_q;
  logic [DATA_W-1:0]    data_q;

  assign hit_ctrl = evt_i && (word_i.addr == '0);

  for (genvar g = 0; g < NUM_PARAM; g++) begin : g_slot
    assign hit_par[g] = evt_i && (word_i.addr == ADDR_W'(g + 1));
  end

  // targets above NUM_PARAM match nothing and are dropped
  assign any_hit = hit_ctrl || (|hit_par);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      par_q  <= '0;
      rst_q  <= 1'b0;
      data_q <= '0;
    end else begin
      ctrl_q <= hit_ctrl;
      par_q  <= hit_par;
      rst_q  <= hit_ctrl;
      if (any_hit) data_q <= word_i.data;
    end
  end

  assign ctrl_we_o  = ctrl_q;
  assign param_we_o = par_q;
  assign seq_rst_o  = rst_q;
  assign data_o     = data_q;
endmodule

// File: rtl/serial_cmd_loader.sv
`timescale 1ns/1ps
module serial_cmd_loader
  import scl_pkg::*;
#(
  parameter int unsigned NUM_PARAM   = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sync_ni,
  input  logic                 sdata_i,
  output logic                 ctrl_we_o,
  output logic [NUM_PARAM-1:0] param_we_o,
  output logic                 seq_rst_o,
  output logic [DATA_W-1:0]    wr_data_o
);
  cmd_word_t word_s;
  logic      tog_s;
  logic      word_evt;

  serial_shift_in u_shift (
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sync_ni (sync_ni),
    .sdata_i (sdata_i),
    .word_o  (word_s),
    .tog_o   (tog_s)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tog_i   (tog_s),
    .pulse_o (word_evt)
  );

  cmd_decode #(.NUM_PARAM(NUM_PARAM)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (word_evt),
    .word_i     (word_s),
    .ctrl_we_o  (ctrl_we_o),
    .param_we_o (param_we_o),
    .seq_rst_o  (seq_rst_o),
    .data_o     (wr_data_o)
  );
endmodule

// File: rtl/serial_cmd_loader_chk.sv
`timescale 1ns/1ps
module serial_cmd_loader_chk #(
  parameter int unsigned NUM_PARAM = 7,
  parameter int unsigned DATA_W    = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctrl_we_i,
  input logic [NUM_PARAM-1:0] param_we_i,
  input logic                 seq_rst_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic                 word_evt_i
);
  logic any_we;
  assign any_we = ctrl_we_i || (|param_we_i);

  assert_excl_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_we_i, param_we_i}));

  assert_ctrl_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !ctrl_we_i);

  assert_param_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|param_we_i) |=> !(|param_we_i));

  assert_rst_with_ctrl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |-> seq_rst_i);

  assert_rst_only_ctrl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_i |-> ctrl_we_i);

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_we |-> $stable(wr_data_i));

  assert_strobe_from_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_we |-> $past(word_evt_i));
endmodule

bind serial_cmd_loader serial_cmd_loader_chk #(
  .NUM_PARAM (NUM_PARAM),
  .DATA_W    (scl_pkg::DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_we_i  (ctrl_we_o),
  .param_we_i (param_we_o),
  .seq_rst_i  (seq_rst_o),
  .wr_data_i  (wr_data_o),
  .word_evt_i (word_evt)
);

// File: tb/serial_cmd_loader_bench.sv
`timescale 1ns/1ps
module serial_cmd_loader_bench;
  localparam int NP = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b1;
  logic          sync_n = 1'b1;
  logic          sdata = 1'b0;
  logic          ctrl_we;
  logic [NP-1:0] param_we;
  logic          seq_rst;
  logic [11:0]   wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit free = 0;

  logic [15:0] tx_q [4];
  int          ev_kind [8];
  int          ev_data [8];
  int          ev_rst  [8];
  int          n_ev = 0;
  int          exp_kind [8];
  int          exp_data [8];
  int          exp_n = 0;
  int          width_err = 0;
  bit          prev_any = 0;

  serial_cmd_loader u_serial_cmd_loader (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .sync_ni    (sync_n),
    .sdata_i    (sdata),
    .ctrl_we_o  (ctrl_we),
    .param_we_o (param_we),
    .seq_rst_o  (seq_rst),
    .wr_data_o  (wr_data)
  );

  always #5 clk = ~clk;

  initial forever begin
    if (free) #50 sclk = ~sclk;
    else      #10;
  end

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    bit any;
    any = ctrl_we || (|param_we);
    if ($countones({ctrl_we, param_we}) > 1) width_err++;
    if (any) begin
      if (prev_any) width_err++;
      if (n_ev < 8) begin
        ev_kind[n_ev] = -1;
        if (ctrl_we) ev_kind[n_ev] = 0;
        for (int k = 0; k < NP; k++) if (param_we[k]) ev_kind[n_ev] = k + 1;
        ev_data[n_ev] = int'(wr_data);
        ev_rst[n_ev]  = int'(seq_rst);
      end
      n_ev++;
    end else if (seq_rst) begin
      width_err++;
    end
    prev_any = any;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic verify(input string req);
    check({req, " event count"}, n_ev, exp_n);
    for (int i = 0; i < exp_n && i < n_ev && i < 8; i++) begin
      check({req, " target"}, ev_kind[i], exp_kind[i]);
      check({req, " payload"}, ev_data[i], exp_data[i]);
      check("R6 reset pulse with control write", ev_rst[i], (exp_kind[i] == 0) ? 1 : 0);
    end
  endtask

  task automatic clear_log();
    n_ev = 0;
    exp_n = 0;
  endtask

  task automatic expect_ev(input int kind, input int data);
    exp_kind[exp_n] = kind;
    exp_data[exp_n] = data;
    exp_n++;
  endtask

  // manual clock, idle level chosen by idle_hi; data changes away from falling edges
  task automatic send_frame(input int nbits, input bit idle_hi);
    sclk = idle_hi;
    #100 sync_n = 1'b0;
    #50;
    for (int i = 0; i < nbits; i++) begin
      sdata = tx_q[i / 16][15 - (i % 16)];
      if (idle_hi) begin
        #25 sclk = 1'b0;
        #50 sclk = 1'b1;
        #25;
      end else begin
        #25 sclk = 1'b1;
        #50 sclk = 1'b0;
        #25;
      end
    end
    #50 sync_n = 1'b1;
    #400;
  endtask

  task automatic send_frame_cont(input int nbits);
    free = 1;
    @(posedge sclk);
    #10 sync_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdata = tx_q[i / 16][15 - (i % 16)];
      @(negedge sclk);
      #10;
    end
    sync_n = 1'b1;
    #400;
    free = 0;
    #100;
  endtask

  task automatic t_reset();
    check("R10 control strobe at reset", int'(ctrl_we), 0);
    check("R10 parameter strobes at reset", int'(param_we), 0);
    check("R10 reset pulse at reset", int'(seq_rst), 0);
    check("R10 payload at reset", int'(wr_data), 0);
  endtask

  task automatic t_ctrl_idle_high();
    clear_log();
    tx_q[0] = 16'h0ABC;
    send_frame(16, 1'b1);
    expect_ev(0, 12'hABC);
    verify("R2 R4 R9 idle-high control write");
  endtask

  task automatic t_param_idle_low();
    clear_log();
    tx_q[0] = 16'h3123;
    send_frame(16, 1'b0);
    expect_ev(3, 12'h123);
    verify("R5 R9 idle-low parameter write");
  endtask

  task automatic t_stream();
    clear_log();
    tx_q[0] = 16'h1111;
    tx_q[1] = 16'h2FFF;
    tx_q[2] = 16'h05A5;
    tx_q[3] = 16'h7001;
    send_frame(64, 1'b1);
    expect_ev(1, 12'h111);
    expect_ev(2, 12'hFFF);
    expect_ev(0, 12'h5A5);
    expect_ev(7, 12'h001);
    verify("R3 four words in one frame");
  endtask

  task automatic t_continuous();
    clear_log();
    tx_q[0] = 16'h5800;
    tx_q[1] = 16'h6C3E;
    send_frame_cont(32);
    expect_ev(5, 12'h800);
    expect_ev(6, 12'hC3E);
    verify("R9 continuous serial clock");
  endtask

  task automatic t_partial();
    clear_log();
    tx_q[0] = 16'h0FFF;
    send_frame(7, 1'b1);
    check("R1 partial word dropped", n_ev, 0);
    tx_q[0] = 16'h4321;
    send_frame(16, 1'b0);
    expect_ev(4, 12'h321);
    verify("R1 word after partial frame");
  endtask

  task automatic t_clock_while_idle();
    clear_log();
    sdata = 1'b1;
    free = 1;
    #3000;
    free = 0;
    #200;
    check("R1 edges with frame high", n_ev, 0);
  endtask

  task automatic t_reserved();
    clear_log();
    tx_q[0] = 16'h8777;
    tx_q[1] = 16'hF0AA;
    send_frame(32, 1'b1);
    check("R7 reserved targets raise no strobe", n_ev, 0);
    check("R7 payload unchanged by reserved targets", int'(wr_data), 12'h321);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #23;
    t_reset();
    #20 rst_n = 1'b1;
    #50;
    t_ctrl_idle_high();
    t_param_idle_low();
    t_stream();
    t_continuous();
    t_partial();
    t_clock_while_idle();
    t_reserved();
    check("R8 one-cycle exclusive strobes", width_err, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule